// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block translates a 32-bit virtual address into a physical address by walking a two-level page table held in memory. The table layout is the classic non-extended 32-bit scheme. A client raises a one-cycle request that carries the address, the access kind (read or write, user or supervisor) and the paging controls: paging enable, supervisor write protection, large-page enable, the A20 gate and the directory base frame. The walker fetches the directory entry and, for 4 KiB pages, the table entry over a single read/write memory port. It waits for a read-valid strobe on each fetch.

The walker merges and checks the permission bits of the entries it reads. It writes the accessed and dirty bits back to memory when they must change. It ends each request with a one-cycle `done` strobe that carries one of two results. A successful walk returns a physical address and a write-grant flag. A failed walk raises a fault flag with a 3-bit page-fault code. Write grant is reported only when the leaf entry is dirty by the end of the walk. A later write to a clean page therefore comes back through the walker, which sets the dirty bit.

Top module: `pt_walker`

## Requirements
- R1: After a synchronous active-low reset, `busy`, `done`, `fault`, `mem_rd` and `mem_wr` are all low.
- R2: A request with `pg_on` low completes with no memory access. It returns `pa` equal to `va` with the A20 mask applied, and `wr_grant` high.
- R3: The directory entry is read at address `{dir_base, 12'h000} + {va[31:22], 2'b00}`, ANDed with the A20 mask.
- R4: The table entry is read at address `{pde[31:12], 12'h000} + {va[21:12], 2'b00}`, ANDed with the A20 mask. The result is `{pte[31:12], va[11:0]}`.
- R5: A directory entry with bit 7 set maps a 4 MiB page, giving `{pde[31:22], va[21:0]}`, only while `pse_on` is high. When `pse_on` is low, bit 7 is ignored and a table entry is fetched.
- R6: Entry bit 0 is present, bit 1 is writable and bit 2 is user-accessible. For a 4 KiB page, the effective writable and user bits are the AND of the directory and table entry bits.
- R7: A user access faults when the effective user bit is 0. A user write faults when the effective writable bit is 0. A supervisor write faults on a clear writable bit only when `wp_on` is high. Supervisor reads never fault on permissions.
- R8: Entry bit 5 is accessed and bit 6 is dirty. A directory entry with bit 5 clear is written back with bit 5 set before the table fetch. The leaf entry is written back with bit 5 set, and with bit 6 set on a write, only when one of these bits changes. No leaf write-back happens on a fault.
- R9: A fault completes with `fault` high for the one `done` cycle, `pa` zero and `wr_grant` low. In `err_code`, bit 0 is 1 for a permission violation and 0 for a non-present entry, bit 1 is the write flag and bit 2 is the user flag.
- R10: On success, `wr_grant` is high only if the leaf entry is dirty after the walk. In addition, the access must be one of: a user access with the effective writable bit set, or a supervisor access with `wp_on` low or the writable bit set.
- R11: With `a20_on` low, bit 20 of every entry address and of the returned physical address is forced to 0.
- R12: `done` is a single-cycle strobe while `busy` is high, and a `req` that arrives while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Start a walk (sampled when idle) |
| va | input | 32 | Virtual address |
| acc_wr | input | 1 | Access is a write |
| acc_usr | input | 1 | Access is from user level |
| pg_on | input | 1 | Paging enabled |
| wp_on | input | 1 | Supervisor write protection enabled |
| pse_on | input | 1 | 4 MiB pages enabled |
| a20_on | input | 1 | A20 gate open (bit 20 passes) |
| dir_base | input | 20 | Page directory frame number |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion strobe |
| fault | output | 1 | Walk failed (valid with done) |
| err_code | output | 3 | Page-fault code (valid with done) |
| pa | output | 32 | Physical address (valid with done) |
| wr_grant | output | 1 | Write right granted (valid with done) |
| mem_rd | output | 1 | Memory read request, held until valid |
| mem_wr | output | 1 | One-cycle memory write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |

## Verification
A fixed memory image holds two small tables and a 4 MiB entry. The walks against it cover clean, dirty, read-only, supervisor-only and non-present entries. Each access kind is tried with write protection both on and off, so that the protection rules of R7 and R10 are told apart one at a time. Repeating a walk after a write-back shows that the accessed and dirty bits stick: the write-back count drops to zero and write grant appears. Further walks cover large pages with the large-page enable cleared, paging off, and the A20 gate closed. These show that the address is formed by the intended path rather than by a neighbouring one.

// File: rtl/pt_walker_pkg.sv
// Shared constants, types and helpers for the page table walker.
// Assumes 32-bit virtual and physical addresses and 4-byte entries.
package pt_walker_pkg;
    localparam int ADDR_W   = 32;
    localparam int PAGE_SH  = 12;
    localparam int LARGE_SH = 22;
    localparam int FRAME_W  = ADDR_W - PAGE_SH;
    localparam int IDX_W    = LARGE_SH - PAGE_SH;
    localparam int A20_BIT  = 20;

    // entry bit positions
    localparam int B_PRES = 0;
    localparam int B_RW   = 1;
    localparam int B_USR  = 2;
    localparam int B_ACC  = 5;
    localparam int B_DRT  = 6;
    localparam int B_PS   = 7;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DIR_RD,
        ST_DIR_WB,
        ST_TBL_RD,
        ST_LEAF_WB,
        ST_RESP
    } walk_state_e;

    // Clear address bit 20 when the gate is closed.
    function automatic logic [ADDR_W-1:0] a20_apply(input logic [ADDR_W-1:0] a,
                                                    input logic gate_open);
        logic [ADDR_W-1:0] m;
        m = '1;
        m[A20_BIT] = gate_open;
        return a & m;
    endfunction
endpackage

// File: rtl/pt_walker_addr.sv
// Entry address generator: forms directory and table entry addresses from
// the directory base, the virtual address and the directory entry frame,
// then applies the A20 mask. Purely combinational.
module pt_walker_addr
    import pt_walker_pkg::*;
(
    input  logic [FRAME_W-1:0] dir_frame,
    input  logic [FRAME_W-1:0] va_hi,
    input  logic [FRAME_W-1:0] pde_frame,
    input  logic               a20_open,
    output logic [ADDR_W-1:0]  pde_addr,
    output logic [ADDR_W-1:0]  pte_addr
);
    localparam int DIR_IDX_W = ADDR_W - LARGE_SH;

    logic [ADDR_W-1:0] dir_off, tbl_off;

    // index offsets scaled by the 4-byte entry size
    always_comb begin
        dir_off = {{(ADDR_W-DIR_IDX_W-2){1'b0}}, va_hi[FRAME_W-1:IDX_W], 2'b00};
        tbl_off = {{(ADDR_W-IDX_W-2){1'b0}}, va_hi[IDX_W-1:0], 2'b00};
    end

    // base plus offset, then the gate mask
    always_comb begin
        pde_addr = a20_apply({dir_frame, {PAGE_SH{1'b0}}} + dir_off, a20_open);
        pte_addr = a20_apply({pde_frame, {PAGE_SH{1'b0}}} + tbl_off, a20_open);
    end
endmodule

// File: rtl/pt_walker_perm.sv
// Permission and status evaluator for one leaf mapping. Takes the effective
// user/writable bits and the leaf accessed/dirty bits; reports a violation,
// whether a write-back is needed and whether write right is granted.
module pt_walker_perm (
    input  logic ent_usr,
    input  logic ent_rw,
    input  logic ent_acc,
    input  logic ent_drt,
    input  logic acc_wr,
    input  logic acc_usr,
    input  logic wp_on,
    output logic viol,
    output logic need_wb,
    output logic wr_ok
);
    logic drt_after;

    // protection rules for user and supervisor accesses
    always_comb begin
        if (acc_usr) viol = !ent_usr || (acc_wr && !ent_rw);
        else         viol = wp_on && acc_wr && !ent_rw;
    end

    // write-back need and write grant after the dirty update
    always_comb begin
        need_wb   = !ent_acc || (acc_wr && !ent_drt);
        drt_after = ent_drt || acc_wr;
        wr_ok     = drt_after && (acc_usr ? ent_rw : (!wp_on || ent_rw));
    end
endmodule

// File: rtl/pt_walker.sv
// Two-level page table walker. Accepts one request at a time, reads the
// directory entry and, for 4 KiB pages, the table entry; sets accessed and
// dirty bits by write-back; returns a physical address with write grant, or
// a fault code. Assumes memory answers each read with one mem_rvalid pulse
// while mem_rd is held, and accepts a write in the cycle mem_wr is high.
module pt_walker
    import pt_walker_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req,
    input  logic [ADDR_W-1:0]  va,
    input  logic               acc_wr,
    input  logic               acc_usr,
    input  logic               pg_on,
    input  logic               wp_on,
    input  logic               pse_on,
    input  logic               a20_on,
    input  logic [FRAME_W-1:0] dir_base,
    output logic               busy,
    output logic               done,
    output logic               fault,
    output logic [2:0]         err_code,
    output logic [ADDR_W-1:0]  pa,
    output logic               wr_grant,
    output logic               mem_rd,
    output logic               mem_wr,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [ADDR_W-1:0]  mem_wdata,
    input  logic               mem_rvalid,
    input  logic [ADDR_W-1:0]  mem_rdata
);
    walk_state_e        st_q;
    logic [ADDR_W-1:0]  va_q, pde_q, leaf_addr_q, leaf_new_q, pa_q;
    logic [FRAME_W-1:0] cr3_q;
    logic               wr_q, usr_q, wp_q, pse_q, a20_q;
    logic               grant_q, fault_q;
    logic [2:0]         err_q;

    logic [ADDR_W-1:0]  pde_addr, pte_addr, leaf_pa, leaf_new;
    logic               in_tbl, is_large, leaf_now;
    logic               e_usr, e_rw, viol, need_wb, wr_ok;

    pt_walker_addr u_addr (
        .dir_frame (cr3_q),
        .va_hi     (va_q[ADDR_W-1:PAGE_SH]),
        .pde_frame (pde_q[ADDR_W-1:PAGE_SH]),
        .a20_open  (a20_q),
        .pde_addr  (pde_addr),
        .pte_addr  (pte_addr)
    );

    // entry decode for the fetch in progress
    always_comb begin
        in_tbl   = (st_q == ST_TBL_RD);
        is_large = (st_q == ST_DIR_RD) && mem_rdata[B_PS] && pse_q;
        leaf_now = in_tbl || is_large;
        e_usr    = mem_rdata[B_USR] & (in_tbl ? pde_q[B_USR] : 1'b1);
        e_rw     = mem_rdata[B_RW]  & (in_tbl ? pde_q[B_RW]  : 1'b1);
        leaf_new = mem_rdata;
        leaf_new[B_ACC] = 1'b1;
        leaf_new[B_DRT] = mem_rdata[B_DRT] | wr_q;
        leaf_pa  = is_large
                 ? a20_apply({mem_rdata[ADDR_W-1:LARGE_SH], va_q[LARGE_SH-1:0]}, a20_q)
                 : a20_apply({mem_rdata[ADDR_W-1:PAGE_SH], va_q[PAGE_SH-1:0]}, a20_q);
    end

    pt_walker_perm u_perm (
        .ent_usr (e_usr),
        .ent_rw  (e_rw),
        .ent_acc (mem_rdata[B_ACC]),
        .ent_drt (mem_rdata[B_DRT]),
        .acc_wr  (wr_q),
        .acc_usr (usr_q),
        .wp_on   (wp_q),
        .viol    (viol),
        .need_wb (need_wb),
        .wr_ok   (wr_ok)
    );

    // walk sequencer and result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q        <= ST_IDLE;
            va_q        <= '0;
            cr3_q       <= '0;
            pde_q       <= '0;
            leaf_addr_q <= '0;
            leaf_new_q  <= '0;
            pa_q        <= '0;
            wr_q        <= 1'b0;
            usr_q       <= 1'b0;
            wp_q        <= 1'b0;
            pse_q       <= 1'b0;
            a20_q       <= 1'b0;
            grant_q     <= 1'b0;
            fault_q     <= 1'b0;
            err_q       <= '0;
        end else begin
            case (st_q)
                ST_IDLE: if (req) begin
                    va_q    <= va;
                    cr3_q   <= dir_base;
                    wr_q    <= acc_wr;
                    usr_q   <= acc_usr;
                    wp_q    <= wp_on;
                    pse_q   <= pse_on;
                    a20_q   <= a20_on;
                    fault_q <= 1'b0;
                    err_q   <= '0;
                    grant_q <= 1'b1;
                    pa_q    <= a20_apply(va, a20_on);
                    st_q    <= pg_on ? ST_DIR_RD : ST_RESP;
                end
                ST_DIR_RD, ST_TBL_RD: if (mem_rvalid) begin
                    if (!in_tbl) pde_q <= mem_rdata;
                    if (!mem_rdata[B_PRES] || (leaf_now && viol)) begin
                        fault_q <= 1'b1;
                        err_q   <= {usr_q, wr_q, mem_rdata[B_PRES]};
                        pa_q    <= '0;
                        grant_q <= 1'b0;
                        st_q    <= ST_RESP;
                    end else if (leaf_now) begin
                        pa_q        <= leaf_pa;
                        grant_q     <= wr_ok;
                        leaf_addr_q <= in_tbl ? pte_addr : pde_addr;
                        leaf_new_q  <= leaf_new;
                        st_q        <= need_wb ? ST_LEAF_WB : ST_RESP;
                    end else begin
                        st_q <= mem_rdata[B_ACC] ? ST_TBL_RD : ST_DIR_WB;
                    end
                end
                ST_DIR_WB:  st_q <= ST_TBL_RD;
                ST_LEAF_WB: st_q <= ST_RESP;
                default:    st_q <= ST_IDLE;
            endcase
        end
    end

    // memory port drive from the current state
    always_comb begin
        mem_rd    = (st_q == ST_DIR_RD) || (st_q == ST_TBL_RD);
        mem_wr    = (st_q == ST_DIR_WB) || (st_q == ST_LEAF_WB);
        mem_wdata = '0;
        case (st_q)
            ST_DIR_RD:  mem_addr = pde_addr;
            ST_DIR_WB: begin
                mem_addr         = pde_addr;
                mem_wdata        = pde_q;
                mem_wdata[B_ACC] = 1'b1;
            end
            ST_TBL_RD:  mem_addr = pte_addr;
            ST_LEAF_WB: begin
                mem_addr  = leaf_addr_q;
                mem_wdata = leaf_new_q;
            end
            default:    mem_addr = '0;
        endcase
    end

    // response outputs
    always_comb begin
        busy     = (st_q != ST_IDLE);
        done     = (st_q == ST_RESP);
        fault    = done && fault_q;
        err_code = err_q;
        pa       = pa_q;
        wr_grant = grant_q;
    end
endmodule

// File: rtl/pt_walker_chk.sv
// Protocol checker for the page table walker, bound to every instance.
module pt_walker_chk
    import pt_walker_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic              fault,
    input logic [2:0]        err_code,
    input logic [ADDR_W-1:0] pa,
    input logic              wr_grant,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic [ADDR_W-1:0] mem_wdata
);
    a_r9_fault_zero_pa: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fault) |-> (pa == '0 && !wr_grant));

    a_r9_code_only_on_fault: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !fault) |-> (err_code == 3'b000));

    a_r12_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r12_done_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    a_r8_wb_sets_accessed: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> mem_wdata[B_ACC]);

    a_r8_port_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));
endmodule

bind pt_walker pt_walker_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .done      (done),
    .fault     (fault),
    .err_code  (err_code),
    .pa        (pa),
    .wr_grant  (wr_grant),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .mem_wdata (mem_wdata)
);

// File: tb/pt_walker_bench.sv
module pt_walker_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 17;

    typedef struct packed {
        logic [31:0] va;
        logic        wr, usr, pg, wp, pse, a20;
        logic        e_fault;
        logic [2:0]  e_err;
        logic [31:0] e_pa;
        logic        e_wok;
        logic [2:0]  e_wb;
    } vec_t;

    // va, wr, usr, pg, wp, pse, a20, fault, err, pa, wr_grant, write-backs
    localparam vec_t VECS [NVEC] = '{
        '{32'h0000_0ABC, 1'b0,1'b1,1'b1,1'b0,1'b1,1'b1, 1'b0,3'd0, 32'h0010_0ABC, 1'b1, 3'd1}, // R3 R4 R8 dir A
        '{32'h0000_1234, 1'b1,1'b0,1'b1,1'b1,1'b1,1'b1, 1'b0,3'd0, 32'h0020_0234, 1'b1, 3'd1}, // R8 leaf A|D
        '{32'h0000_1234, 1'b0,1'b1,1'b1,1'b1,1'b1,1'b1, 1'b1,3'd5, 32'h0,         1'b0, 3'd0}, // R6 R7 user bit
        '{32'h0000_2000, 1'b0,1'b0,1'b1,1'b1,1'b1,1'b1, 1'b1,3'd0, 32'h0,         1'b0, 3'd0}, // R9 pte absent
        '{32'h0000_3010, 1'b1,1'b1,1'b1,1'b1,1'b1,1'b1, 1'b1,3'd7, 32'h0,         1'b0, 3'd0}, // R7 user write ro
        '{32'h0000_3010, 1'b1,1'b0,1'b1,1'b0,1'b1,1'b1, 1'b0,3'd0, 32'h0030_0010, 1'b1, 3'd0}, // R7 sup no wp
        '{32'h0000_3010, 1'b1,1'b0,1'b1,1'b1,1'b1,1'b1, 1'b1,3'd3, 32'h0,         1'b0, 3'd0}, // R7 sup wp
        '{32'h0000_3010, 1'b0,1'b0,1'b1,1'b1,1'b1,1'b1, 1'b0,3'd0, 32'h0030_0010, 1'b0, 3'd0}, // R10 wp ro
        '{32'h0080_0000, 1'b0,1'b1,1'b1,1'b0,1'b1,1'b1, 1'b1,3'd4, 32'h0,         1'b0, 3'd0}, // R9 pde absent
        '{32'h0045_6789, 1'b0,1'b1,1'b1,1'b0,1'b1,1'b1, 1'b0,3'd0, 32'h0805_6789, 1'b0, 3'd1}, // R5 large clean
        '{32'h0045_6789, 1'b1,1'b1,1'b1,1'b0,1'b1,1'b1, 1'b0,3'd0, 32'h0805_6789, 1'b1, 3'd1}, // R5 R10 large dirty
        '{32'h0045_6789, 1'b0,1'b0,1'b1,1'b0,1'b0,1'b1, 1'b1,3'd0, 32'h0,         1'b0, 3'd0}, // R5 pse off
        '{32'h00C0_0444, 1'b0,1'b1,1'b1,1'b0,1'b1,1'b1, 1'b0,3'd0, 32'h0050_0444, 1'b0, 3'd0}, // R6 dir rw=0
        '{32'h00C0_0444, 1'b1,1'b0,1'b1,1'b0,1'b1,1'b1, 1'b0,3'd0, 32'h0050_0444, 1'b1, 3'd0}, // R10 sup dirty
        '{32'h1234_5678, 1'b0,1'b1,1'b0,1'b1,1'b1,1'b1, 1'b0,3'd0, 32'h1234_5678, 1'b1, 3'd0}, // R2 paging off
        '{32'h0017_0ABC, 1'b0,1'b1,1'b0,1'b0,1'b1,1'b0, 1'b0,3'd0, 32'h0007_0ABC, 1'b1, 3'd0}, // R11 R2 gate
        '{32'h0000_0ABC, 1'b0,1'b1,1'b1,1'b0,1'b1,1'b0, 1'b0,3'd0, 32'h0000_0ABC, 1'b1, 3'd0}  // R11 walk gate
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic [31:0] va = '0;
    logic        acc_wr = 1'b0, acc_usr = 1'b0, pg_on = 1'b0, wp_on = 1'b0;
    logic        pse_on = 1'b0, a20_on = 1'b1;
    logic [19:0] dir_base = 20'h00001;
    logic        busy, done, fault, wr_grant, mem_rd, mem_wr;
    logic [2:0]  err_code;
    logic [31:0] pa, mem_addr, mem_wdata;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;

    logic [31:0] mem [0:4095];
    int rd_wait = 0;
    int wb_cnt = 0;
    int checks = 0;
    int errors = 0;
    bit timed_out = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pt_walker u_pt_walker (
        .clk(clk), .rst_n(rst_n), .req(req), .va(va), .acc_wr(acc_wr),
        .acc_usr(acc_usr), .pg_on(pg_on), .wp_on(wp_on), .pse_on(pse_on),
        .a20_on(a20_on), .dir_base(dir_base), .busy(busy), .done(done),
        .fault(fault), .err_code(err_code), .pa(pa), .wr_grant(wr_grant),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
    );

    // memory model: 16 KiB, reads answer after two cycles, out of range reads 0
    always @(posedge clk) begin
        if (mem_wr) begin
            wb_cnt <= wb_cnt + 1;
            if (mem_addr < 32'h4000) mem[mem_addr[13:2]] <= mem_wdata;
        end
        if (mem_rd && !mem_rvalid) begin
            if (rd_wait == 1) begin
                mem_rvalid <= 1'b1;
                mem_rdata  <= (mem_addr < 32'h4000) ? mem[mem_addr[13:2]] : 32'h0;
                rd_wait    <= 0;
            end else begin
                rd_wait <= rd_wait + 1;
            end
        end else begin
            mem_rvalid <= 1'b0;
            rd_wait    <= 0;
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic walk(input vec_t v);
        @(negedge clk);
        va = v.va; acc_wr = v.wr; acc_usr = v.usr; pg_on = v.pg;
        wp_on = v.wp; pse_on = v.pse; a20_on = v.a20;
        wb_cnt = 0;
        req = 1'b1;
        @(negedge clk);
        req = 1'b0;
        for (int t = 0; t < 200 && !done; t++) @(negedge clk);
        if (!done) timed_out = 1'b1;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4096; i++) mem[i] = 32'h0;
        mem[12'h400] = 32'h0000_2007;  // dir 0 -> table 0x2000, A clear
        mem[12'h401] = 32'h0800_0087;  // dir 1 -> 4 MiB page, clean
        mem[12'h403] = 32'h0000_3025;  // dir 3 -> table 0x3000, read-only
        mem[12'h800] = 32'h0010_0067;  // user rw, A and D set
        mem[12'h801] = 32'h0020_0003;  // supervisor only, clean
        mem[12'h803] = 32'h0030_0065;  // user read-only, dirty
        mem[12'hC00] = 32'h0050_0067;  // user rw, dirty
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(!busy && !done && !fault, "R1 idle flags", {29'b0, busy, done, fault}, 32'h0);
        check(!mem_rd && !mem_wr, "R1 memory port idle", {30'b0, mem_rd, mem_wr}, 32'h0);

        for (int i = 0; i < NVEC; i++) begin
            walk(VECS[i]);
            check(!timed_out, "R12 walk completes", {31'b0, done}, 32'h1);
            check(fault == VECS[i].e_fault, "R7/R9 fault flag", {31'b0, fault}, {31'b0, VECS[i].e_fault});
            check(err_code == VECS[i].e_err, "R9 error code", {29'b0, err_code}, {29'b0, VECS[i].e_err});
            check(pa == VECS[i].e_pa, "R3/R4/R5/R11 phys addr", pa, VECS[i].e_pa);
            check(wr_grant == VECS[i].e_wok, "R10 write grant", {31'b0, wr_grant}, {31'b0, VECS[i].e_wok});
            check(wb_cnt == int'(VECS[i].e_wb), "R8 write-back count", wb_cnt, {29'b0, VECS[i].e_wb});
            @(negedge clk);
            check(!done, "R12 done one cycle", {31'b0, done}, 32'h0);
        end

        // R8 memory image after write-backs
        check(mem[12'h400] == 32'h0000_2027, "R8 dir accessed set", mem[12'h400], 32'h0000_2027);
        check(mem[12'h801] == 32'h0020_0063, "R8 leaf A and D set", mem[12'h801], 32'h0020_0063);
        check(mem[12'h401] == 32'h0800_00E7, "R8 large A and D set", mem[12'h401], 32'h0800_00E7);
        check(mem[12'h803] == 32'h0030_0065, "R8 faulted leaf untouched", mem[12'h803], 32'h0030_0065);

        // R12 request while busy is ignored
        @(negedge clk);
        va = 32'h0000_0ABC; acc_wr = 1'b0; acc_usr = 1'b0; pg_on = 1'b1;
        wp_on = 1'b0; pse_on = 1'b1; a20_on = 1'b1;
        req = 1'b1;
        @(negedge clk);
        req = 1'b0;
        @(negedge clk);
        check(busy, "R12 busy during walk", {31'b0, busy}, 32'h1);
        va = 32'h0000_3010; acc_wr = 1'b1;
        req = 1'b1;
        @(negedge clk);
        req = 1'b0;
        for (int t = 0; t < 200 && !done; t++) @(negedge clk);
        check(done && pa == 32'h0010_0ABC, "R12 first request served", pa, 32'h0010_0ABC);
        begin
            bit extra = 1'b0;
            for (int t = 0; t < 8; t++) begin
                @(negedge clk);
                if (done) extra = 1'b1;
            end
            check(!extra && !busy, "R12 second request dropped", {30'b0, extra, busy}, 32'h0);
        end

        if (timed_out) begin
            checks++; errors++;
            $display("FAIL R12 walk timed out");
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule